// File: doc/BRIEF.md
# Display frame configuration sequencer

This block paces display frames from elapsed time and turns the display configuration inputs into one frame descriptor per frame. Each cycle the host may present a time step in nanoseconds. The block adds that step to an accumulator. Whenever the accumulator has reached one frame period, the block takes one period off and starts a frame. A single large step can hold several periods, and the block then issues those frames one after another.

For each frame the block samples the geometry word, the enable bits, the pixel format, the interlace and blank requests, the border colour and the address inputs. From them it builds a descriptor: enable, start address, row pitch in bytes, width in pixels, height in lines, format, and blank/border. Enabled frames alternate between two descriptor slots. The block raises a format-change flag when the new width, height or format differs from the one stored in the other slot. Every frame, enabled or not, is followed by three event pulses and advances a frame counter. The pulses are scanline 1, then scanline 2, then retrace.

Top module: `frame_cfg_seq`

## Requirements
- R1: The accumulator adds `step_ns` on every cycle where `step_valid` is high. In any cycle where the block is idle and the accumulator holds at least PERIOD (default 20,000,000), a frame starts and PERIOD is subtracted. Whatever remains is kept, and one step of k periods yields k frames. `frame_pulse` is high in the second cycle after the cycle in which the step is presented.
- R2: `disp_geom` holds three 10-bit fields: the words-per-line field at bits 9:0, the lines field at bits 19:10 and the modulo field at bits 29:20. `vres` equals the lines field plus 1. When `interlace` is high, that value is doubled.
- R3: `row_bytes` equals 4 × ((words field + 1) + (modulo field − 1)).
- R4: `hres` is derived from W = words field + 1 and depends on `pix_fmt`. Codes 0 (15-bit) and 1 (16-bit) give 2W. Code 2 (24-bit) gives floor(4W/3). Code 3 (32-bit) gives W.
- R5: A frame is enabled (`frame_en`=1) only when `disp_enable` and `video_out` are both high.
- R6: `slot` names the descriptor slot an enabled frame occupies. Consecutive enabled frames alternate between slot 0 and slot 1, and the first enabled frame after reset uses slot 0.
- R7: On an enabled frame, `fmt_change` is high exactly when `hres`, `vres` or the format differs from the values stored in the other slot. After reset, both slots hold zero resolution and format 0.
- R8: On an enabled frame, `blank_out` copies `blank_req` and `border_out` carries `border_color`.
- R9: A disabled frame reports `frame_en`=0, `slot`=0, `fmt_change`=0 and `blank_out`=0. It returns the slot index to 0 and zeroes slot 0's stored resolution, while slot 1 keeps its contents.
- R10: `frame_count` rises by exactly one on every frame, enabled or not.
- R11: After each `frame_pulse` cycle come one cycle each of `scanline1`, `scanline2` and `retrace`, in that order. Each of these four outputs is high for one cycle, and no two are high together.
- R12: `start_addr` is latched at the frame as `vram_base + disp_addr`.
- R13: After reset, all pulses, `frame_en`, `slot` and `frame_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | A time step is present this cycle |
| step_ns | input | TIME_W | Elapsed time in ns |
| disp_geom | input | 3*FIELD_W | Geometry word: modulo, lines, words per line |
| disp_enable | input | 1 | Display enable |
| video_out | input | 1 | Video output enable |
| interlace | input | 1 | Interlaced mode; doubles the line count |
| pix_fmt | input | 2 | 0=15-bit, 1=16-bit, 2=24-bit, 3=32-bit |
| blank_req | input | 1 | Output a border-colour blank frame |
| border_color | input | COL_W | Border colour |
| vram_base | input | ADDR_W | Video memory base |
| disp_addr | input | ADDR_W | Display start offset |
| frame_pulse | output | 1 | Descriptor valid for one cycle |
| frame_en | output | 1 | Frame is enabled |
| start_addr | output | ADDR_W | Frame start address |
| row_bytes | output | FIELD_W+3 | Row pitch in bytes |
| hres | output | FIELD_W+3 | Width in pixels |
| vres | output | FIELD_W+2 | Height in lines |
| fmt_out | output | 2 | Frame format |
| fmt_change | output | 1 | Output format differs from the previous slot |
| blank_out | output | 1 | Frame is blank |
| border_out | output | COL_W | Colour used for a blank frame |
| slot | output | 1 | Descriptor slot used |
| frame_count | output | CNT_W | Frames issued |
| scanline1 | output | 1 | First scanline event |
| scanline2 | output | 1 | Second scanline event |
| retrace | output | 1 | Retrace event |

## Verification
Faults in the accumulator show up as a wrong number of `frame_pulse` cycles. Frames appear early, late or missing after a split or multi-period step, and a counting window of a few dozen cycles exposes this. Faults in the slot index or the stored slot contents change no descriptor field directly. They appear only as a wrong `slot` value or a wrong `fmt_change` on the next enabled frame, so the stimulus sequence must alternate slots and also repeat the same configuration. Event ordering faults appear within the three cycles that follow each frame.

// File: rtl/frame_cfg_seq.sv
module frame_cfg_seq #(
  parameter int TIME_W  = 32,
  parameter int PERIOD  = 20_000_000,
  parameter int FIELD_W = 10,
  parameter int ADDR_W  = 32,
  parameter int COL_W   = 24,
  parameter int CNT_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_valid,
  input  logic [TIME_W-1:0]    step_ns,
  input  logic [3*FIELD_W-1:0] disp_geom,
  input  logic                 disp_enable,
  input  logic                 video_out,
  input  logic                 interlace,
  input  logic [1:0]           pix_fmt,
  input  logic                 blank_req,
  input  logic [COL_W-1:0]     border_color,
  input  logic [ADDR_W-1:0]    vram_base,
  input  logic [ADDR_W-1:0]    disp_addr,
  output logic                 frame_pulse,
  output logic                 frame_en,
  output logic [ADDR_W-1:0]    start_addr,
  output logic [FIELD_W+2:0]   row_bytes,
  output logic [FIELD_W+2:0]   hres,
  output logic [FIELD_W+1:0]   vres,
  output logic [1:0]           fmt_out,
  output logic                 fmt_change,
  output logic                 blank_out,
  output logic [COL_W-1:0]     border_out,
  output logic                 slot,
  output logic [CNT_W-1:0]     frame_count,
  output logic                 scanline1,
  output logic                 scanline2,
  output logic                 retrace
);
  localparam int ACC_W  = TIME_W + 1;
  localparam int HRES_W = FIELD_W + 3;
  localparam int VRES_W = FIELD_W + 2;
  localparam logic [ACC_W-1:0] PER = ACC_W'(PERIOD);

  typedef enum logic [2:0] {S_IDLE, S_FRM, S_SL1, S_SL2, S_RT} phase_t;
  phase_t phase;

  logic [ACC_W-1:0] acc;
  logic             fire;

  assign fire = (phase == S_IDLE) && (acc >= PER);

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else acc <= acc + (step_valid ? ACC_W'(step_ns) : '0) - (fire ? PER : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= S_IDLE;
    else begin
      case (phase)
        S_IDLE:  if (fire) phase <= S_FRM;
        S_FRM:   phase <= S_SL1;
        S_SL1:   phase <= S_SL2;
        S_SL2:   phase <= S_RT;
        default: phase <= S_IDLE;
      endcase
    end
  end

  assign frame_pulse = phase == S_FRM;
  assign scanline1   = phase == S_SL1;
  assign scanline2   = phase == S_SL2;
  assign retrace     = phase == S_RT;

  logic [FIELD_W-1:0] f_words, f_lines, f_mod;
  assign f_words = disp_geom[FIELD_W-1:0];
  assign f_lines = disp_geom[2*FIELD_W-1:FIELD_W];
  assign f_mod   = disp_geom[3*FIELD_W-1:2*FIELD_W];

  logic [FIELD_W:0]   words, lines, pitch_w;
  logic [FIELD_W+2:0] wx4, q24;
  logic [HRES_W-1:0]  hres_c;
  logic [VRES_W-1:0]  vres_c;
  logic               en_c, chg_c;

  assign words   = {1'b0, f_words} + (FIELD_W+1)'(1);
  assign lines   = {1'b0, f_lines} + (FIELD_W+1)'(1);
  assign pitch_w = {1'b0, f_words} + {1'b0, f_mod};
  assign wx4     = {words, 2'b00};
  assign q24     = wx4 / (FIELD_W+3)'(3);
  assign vres_c  = interlace ? {lines, 1'b0} : {1'b0, lines};
  assign en_c    = disp_enable & video_out;

  always_comb begin
    case (pix_fmt)
      2'd0, 2'd1: hres_c = {1'b0, words, 1'b0};
      2'd2:       hres_c = q24;
      default:    hres_c = {2'b00, words};
    endcase
  end

  logic              idx;
  logic [HRES_W-1:0] s_hres [2];
  logic [VRES_W-1:0] s_vres [2];
  logic [1:0]        s_fmt  [2];

  assign chg_c = (hres_c != s_hres[!idx]) || (vres_c != s_vres[!idx]) || (pix_fmt != s_fmt[!idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        s_hres[i] <= '0;
        s_vres[i] <= '0;
        s_fmt[i]  <= '0;
      end
    end else if (fire) begin
      if (en_c) begin
        idx         <= !idx;
        s_hres[idx] <= hres_c;
        s_vres[idx] <= vres_c;
        s_fmt[idx]  <= pix_fmt;
      end else begin
        idx       <= 1'b0;
        s_hres[0] <= '0;
        s_vres[0] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_en    <= 1'b0;
      start_addr  <= '0;
      row_bytes   <= '0;
      hres        <= '0;
      vres        <= '0;
      fmt_out     <= '0;
      fmt_change  <= 1'b0;
      blank_out   <= 1'b0;
      border_out  <= '0;
      slot        <= 1'b0;
      frame_count <= '0;
    end else if (fire) begin
      frame_count <= frame_count + CNT_W'(1);
      frame_en    <= en_c;
      if (en_c) begin
        start_addr <= vram_base + disp_addr;
        row_bytes  <= {pitch_w, 2'b00};
        hres       <= hres_c;
        vres       <= vres_c;
        fmt_out    <= pix_fmt;
        fmt_change <= chg_c;
        blank_out  <= blank_req;
        border_out <= border_color;
        slot       <= idx;
      end else begin
        fmt_change <= 1'b0;
        blank_out  <= 1'b0;
        slot       <= 1'b0;
      end
    end
  end

  // R11
  events_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_pulse, scanline1, scanline2, retrace}));
  // R11
  frame_then_sl1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> scanline1);
  // R11
  sl1_then_sl2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scanline1 |=> scanline2);
  // R11
  sl2_then_rt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scanline2 |=> retrace);
  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> (frame_count - $past(frame_count)) == CNT_W'(1));
  // R9
  disabled_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pulse && !frame_en) |-> (!slot && !fmt_change && !blank_out));
  // R2
  enabled_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pulse && frame_en) |-> (hres != '0 && vres != '0));
  // R1
  descriptor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scanline1 || scanline2 || retrace) |-> $stable(frame_count));
endmodule

// File: tb/frame_cfg_seq_tb.sv
`timescale 1ns/1ps
module frame_cfg_seq_tb;
  localparam int PER = 20_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_valid = 1'b0;
  logic [31:0] step_ns = '0;
  logic [29:0] disp_geom = '0;
  logic        disp_enable = 1'b1, video_out = 1'b1, interlace = 1'b0, blank_req = 1'b0;
  logic [1:0]  pix_fmt = '0;
  logic [23:0] border_color = 24'h123456;
  logic [31:0] vram_base = 32'h0C00_0000, disp_addr = 32'h0020_0000;

  logic        frame_pulse, frame_en, fmt_change, blank_out, slot;
  logic        scanline1, scanline2, retrace;
  logic [31:0] start_addr;
  logic [12:0] row_bytes, hres;
  logic [11:0] vres;
  logic [1:0]  fmt_out;
  logic [23:0] border_out;
  logic [15:0] frame_count;

  frame_cfg_seq u_dut (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_ns(step_ns),
    .disp_geom(disp_geom), .disp_enable(disp_enable), .video_out(video_out),
    .interlace(interlace), .pix_fmt(pix_fmt), .blank_req(blank_req),
    .border_color(border_color), .vram_base(vram_base), .disp_addr(disp_addr),
    .frame_pulse(frame_pulse), .frame_en(frame_en), .start_addr(start_addr),
    .row_bytes(row_bytes), .hres(hres), .vres(vres), .fmt_out(fmt_out),
    .fmt_change(fmt_change), .blank_out(blank_out), .border_out(border_out),
    .slot(slot), .frame_count(frame_count), .scanline1(scanline1),
    .scanline2(scanline2), .retrace(retrace));

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [9:0]  lines, words, modv;
    logic [1:0]  fmt;
    logic        il, blk;
    logic [12:0] h;
    logic [11:0] v;
    logic [12:0] row;
    logic        chg, sl;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{10'd239,  10'd319,  10'd1,    2'd1, 1'b0, 1'b0, 13'd640,  12'd240,  13'd1280, 1'b1, 1'b0},
    '{10'd239,  10'd319,  10'd1,    2'd1, 1'b0, 1'b0, 13'd640,  12'd240,  13'd1280, 1'b0, 1'b1},
    '{10'd239,  10'd319,  10'd1,    2'd1, 1'b1, 1'b0, 13'd640,  12'd480,  13'd1280, 1'b1, 1'b0},
    '{10'd479,  10'd639,  10'd1,    2'd3, 1'b0, 1'b0, 13'd640,  12'd480,  13'd2560, 1'b1, 1'b1},
    '{10'd479,  10'd479,  10'd1,    2'd2, 1'b0, 1'b0, 13'd640,  12'd480,  13'd1920, 1'b1, 1'b0},
    '{10'd479,  10'd478,  10'd0,    2'd2, 1'b0, 1'b0, 13'd638,  12'd480,  13'd1912, 1'b1, 1'b1},
    '{10'd479,  10'd319,  10'd5,    2'd0, 1'b0, 1'b0, 13'd640,  12'd480,  13'd1296, 1'b1, 1'b0},
    '{10'd479,  10'd319,  10'd5,    2'd1, 1'b0, 1'b1, 13'd640,  12'd480,  13'd1296, 1'b1, 1'b1},
    '{10'd479,  10'd319,  10'd5,    2'd1, 1'b0, 1'b1, 13'd640,  12'd480,  13'd1296, 1'b0, 1'b0},
    '{10'd1023, 10'd1023, 10'd1023, 2'd0, 1'b1, 1'b0, 13'd2048, 12'd2048, 13'd8184, 1'b1, 1'b1}
  };

  int checks = 0, errors = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(input logic [31:0] ns);
    step_valid = 1'b1;
    step_ns = ns;
    @(negedge clk);
    step_valid = 1'b0;
    step_ns = '0;
  endtask

  task automatic frame_and_events();
    step(PER);
    @(negedge clk);
    exp_cnt++;
    chk(frame_pulse == 1'b1, "R1 frame latency", frame_pulse, 1);
    chk(frame_count == 16'(exp_cnt), "R10 frame count", frame_count, exp_cnt);
  endtask

  task automatic events_after();
    @(negedge clk);
    chk(scanline1 && !scanline2 && !retrace && !frame_pulse, "R11 scanline1", scanline1, 1);
    @(negedge clk);
    chk(scanline2 && !scanline1 && !retrace, "R11 scanline2", scanline2, 1);
    @(negedge clk);
    chk(retrace && !scanline2 && !scanline1, "R11 retrace", retrace, 1);
    @(negedge clk);
    chk(!retrace && !frame_pulse, "R11 idle after retrace", retrace, 0);
  endtask

  task automatic count_frames(input int cycles, output int n);
    n = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (frame_pulse) n++;
    end
  endtask

  initial begin
    #200_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(!frame_pulse && !scanline1 && !scanline2 && !retrace, "R13 pulses at reset", frame_pulse, 0);
    chk(!frame_en && !slot && frame_count == 0, "R13 state at reset", frame_count, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      disp_geom = {TBL[i].modv, TBL[i].lines, TBL[i].words};
      pix_fmt   = TBL[i].fmt;
      interlace = TBL[i].il;
      blank_req = TBL[i].blk;
      frame_and_events();
      chk(frame_en == 1'b1, "R5 enabled", frame_en, 1);
      chk(hres == TBL[i].h, "R4 hres", hres, TBL[i].h);
      chk(vres == TBL[i].v, "R2 vres", vres, TBL[i].v);
      chk(row_bytes == TBL[i].row, "R3 row_bytes", row_bytes, TBL[i].row);
      chk(fmt_out == TBL[i].fmt, "R4 fmt_out", fmt_out, TBL[i].fmt);
      chk(fmt_change == TBL[i].chg, "R7 fmt_change", fmt_change, TBL[i].chg);
      chk(slot == TBL[i].sl, "R6 slot", slot, TBL[i].sl);
      chk(blank_out == TBL[i].blk, "R8 blank_out", blank_out, TBL[i].blk);
      if (TBL[i].blk)
        chk(border_out == 24'h123456, "R8 border_out", border_out, 24'h123456);
      chk(start_addr == 32'h0C20_0000, "R12 start_addr", start_addr, 32'h0C20_0000);
      events_after();
    end

    disp_enable = 1'b0;
    frame_and_events();
    chk(!frame_en && !slot && !fmt_change && !blank_out, "R9 display disabled", frame_en, 0);
    events_after();

    disp_enable = 1'b1;
    video_out = 1'b0;
    frame_and_events();
    chk(!frame_en, "R5 video_out low", frame_en, 0);
    events_after();

    video_out = 1'b1;
    disp_addr = 32'h0000_1000;
    frame_and_events();
    chk(slot == 1'b0, "R9 slot restarts at 0", slot, 0);
    chk(fmt_change == 1'b0, "R9 slot 1 kept", fmt_change, 0);
    chk(start_addr == 32'h0C00_1000, "R12 new start_addr", start_addr, 32'h0C00_1000);
    events_after();

    step(PER / 2);
    count_frames(8, n);
    chk(n == 0, "R1 half period gives no frame", n, 0);
    step(PER / 2);
    count_frames(8, n);
    chk(n == 1, "R1 second half gives one frame", n, 1);
    exp_cnt += n;

    step(3 * PER);
    count_frames(25, n);
    chk(n == 3, "R1 three periods give three frames", n, 3);
    exp_cnt += n;
    chk(frame_count == 16'(exp_cnt), "R10 count after burst", frame_count, exp_cnt);

    step(PER + PER / 2);
    count_frames(8, n);
    chk(n == 1, "R1 one and a half periods", n, 1);
    step(PER / 2);
    count_frames(8, n);
    chk(n == 1, "R1 remainder carried", n, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule